// File: doc/BRIEF.md
# Bus-Halting Rectangle Copy Engine

This block moves a rectangle of bytes from one memory area to another on behalf of an 8-bit CPU. Software programs eight byte-wide registers through a small write port. A write to offset 0 arms a transfer. The engine then raises a halt request to the CPU. It waits, staying off the memory bus, until the CPU reports through its two bus-status lines that it has stopped. It then owns the bus and walks the rectangle row by row, performing one read cycle and one write cycle per byte. It can also fill the destination with a constant, using write cycles only. When the last byte is written, it drops the halt request and goes back to idle.

Registers stay writable while the engine waits or runs. A 16-bit CPU store that hits offset 0 and then offset 1 therefore lands completely. The engine copies its working parameters at the moment the bus is granted, including a write arriving in that same cycle. Rows are 256 bytes apart in both areas. A size of zero never wraps a counter. A revision input can alter how the size registers are decoded.

Top module: `blit_engine`

## Requirements
- R1: After reset, `halt_o`, `busy_o`, `mem_rd_o` and `mem_we_o` are all low.
- R2: A register write to offset 0 while idle raises `halt_o` and `busy_o` in the next cycle. A write to any other offset does not start anything.
- R3: After a start, no memory cycle happens until a cycle in which `bus_avail_i` and `bus_state_i` are both high. Either line high on its own is not enough.
- R4: Register writes take effect in every state. The transfer uses the register values as they stand in the grant cycle, including a write made in that same cycle.
- R5: The register offsets are:
  - offset 0: control (bit 0 = fill mode)
  - offset 1: fill byte
  - offsets 2 and 3: source address, high byte then low byte
  - offsets 4 and 5: destination address, high byte then low byte
  - offset 6: width in bytes
  - offset 7: height in rows
- R6: In copy mode (control bit 0 = 0), each byte is handled in two cycles:
  - a read cycle (`mem_rd_o`=1) at source + row*256 + column;
  - then a write cycle (`mem_we_o`=1) at destination + row*256 + column, carrying the byte read.
  
  Columns run from 0 upward within a row, and rows run from 0 upward. Address arithmetic wraps modulo 2^16.
- R7: In fill mode (control bit 0 = 1), there are no read cycles. One write cycle per byte writes the fill byte, in the same address order as R6.
- R8: A width of 0 behaves as 1, and a height of 0 behaves as 1.
- R9: With `rev_sel_i`=1, width and height are XORed with 0x04 before use. With `rev_sel_i`=0, they are used as written.
- R10: `halt_o` and `busy_o` fall in the cycle right after the last write cycle.
- R11: A write to offset 0 while busy does not start a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_sel_i | input | 1 | Revision select: 1 = XOR sizes with 0x04 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| bus_avail_i | input | 1 | CPU bus-available status line |
| bus_state_i | input | 1 | CPU bus-status line |
| halt_o | output | 1 | Halt request to CPU |
| busy_o | output | 1 | High from the cycle after start until halt release |
| mem_addr_o | output | 16 | Memory address |
| mem_rdata_i | input | 8 | Memory read data, valid in the read cycle |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rd_o | output | 1 | Read cycle strobe |
| mem_we_o | output | 1 | Write cycle strobe |

## Verification
The assertions watch the ordering rules on every cycle:
- a rising halt is always preceded by a write to offset 0;
- no memory cycle happens in the first busy cycle;
- read and write never overlap, and every read is followed by a write;
- halt only falls right after a write.

The bench's scenarios cover the rest: the address sequence, the data values, the effect of late and same-cycle register writes, the zero-size and revision decoding, and the refusal of a restart while busy. These are checked against a scoreboard built from the programmed values.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} blit_state_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_FILL   = 1;
  localparam int unsigned REG_SRC_HI = 2;
  localparam int unsigned REG_SRC_LO = 3;
  localparam int unsigned REG_DST_HI = 4;
  localparam int unsigned REG_DST_LO = 5;
  localparam int unsigned REG_WID    = 6;
  localparam int unsigned REG_HGT    = 7;
  localparam int unsigned CTRL_FILL_BIT = 0;
endpackage

// File: rtl/blit_regs.sv
module blit_regs #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 8,
  localparam int unsigned OW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [OW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  regs_nxt_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  // writes accepted in every state; next-value view lets a same-cycle write reach the snapshot
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (addr_i == OW'(g));
    assign regs_nxt_o[g] = hit ? wdata_i : regs_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else         regs_q[g] <= regs_nxt_o[g];
    end
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 16,
  parameter int unsigned NREG       = 8,
  parameter int unsigned ROW_STRIDE = 256,
  parameter logic [7:0]  REV_MASK   = 8'h04
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    grant_i,
  input  logic                    rev_sel_i,
  input  logic [NREG-1:0][DW-1:0] cfg_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic                    halt_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [DW-1:0]           mem_wdata_o,
  output logic                    mem_rd_o,
  output logic                    mem_we_o
);
  localparam logic [AW-1:0] STRIDE = AW'(ROW_STRIDE);

  blit_state_e state_q;
  logic [AW-1:0] src_row_q, dst_row_q;
  logic [DW-1:0] col_q, row_q, wid_q, hgt_q, data_q, fill_q;
  logic          fill_mode_q;

  logic [DW-1:0] wid_eff, hgt_eff;
  logic [DW:0]   col_nxt, row_nxt;
  logic          row_end, job_end;
  logic [AW-1:0] col_ext;

  assign wid_eff = rev_sel_i ? (cfg_i[REG_WID] ^ DW'(REV_MASK)) : cfg_i[REG_WID];
  assign hgt_eff = rev_sel_i ? (cfg_i[REG_HGT] ^ DW'(REV_MASK)) : cfg_i[REG_HGT];

  // >= end test: a zero limit ends after one step instead of wrapping
  assign col_nxt = {1'b0, col_q} + 1'b1;
  assign row_nxt = {1'b0, row_q} + 1'b1;
  assign row_end = col_nxt >= {1'b0, wid_q};
  assign job_end = row_end && (row_nxt >= {1'b0, hgt_q});
  assign col_ext = {{(AW-DW){1'b0}}, col_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      src_row_q   <= '0;
      dst_row_q   <= '0;
      col_q       <= '0;
      row_q       <= '0;
      wid_q       <= '0;
      hgt_q       <= '0;
      data_q      <= '0;
      fill_q      <= '0;
      fill_mode_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_REQ;
        ST_REQ: if (grant_i) begin
          src_row_q   <= {cfg_i[REG_SRC_HI], cfg_i[REG_SRC_LO]};
          dst_row_q   <= {cfg_i[REG_DST_HI], cfg_i[REG_DST_LO]};
          wid_q       <= wid_eff;
          hgt_q       <= hgt_eff;
          fill_q      <= cfg_i[REG_FILL];
          fill_mode_q <= cfg_i[REG_CTRL][CTRL_FILL_BIT];
          col_q       <= '0;
          row_q       <= '0;
          state_q     <= cfg_i[REG_CTRL][CTRL_FILL_BIT] ? ST_WR : ST_RD;
        end
        ST_RD: begin
          data_q  <= mem_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: begin
          if (job_end) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= fill_mode_q ? ST_WR : ST_RD;
            if (row_end) begin
              col_q     <= '0;
              row_q     <= row_nxt[DW-1:0];
              src_row_q <= src_row_q + STRIDE;
              dst_row_q <= dst_row_q + STRIDE;
            end else begin
              col_q <= col_nxt[DW-1:0];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign halt_o      = state_q != ST_IDLE;
  assign mem_rd_o    = state_q == ST_RD;
  assign mem_we_o    = state_q == ST_WR;
  assign mem_wdata_o = fill_mode_q ? fill_q : data_q;
  always_comb begin
    mem_addr_o = '0;
    if (state_q == ST_RD)      mem_addr_o = src_row_q + col_ext;
    else if (state_q == ST_WR) mem_addr_o = dst_row_q + col_ext;
  end

  // R6
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_we_o);
  // R6
  no_rd_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));
  // R10
  release_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> $past(mem_we_o));
endmodule

// File: rtl/blit_engine.sv
module blit_engine #(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 16,
  parameter int unsigned NREG       = 8,
  parameter int unsigned ROW_STRIDE = 256,
  localparam int unsigned OW        = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rev_sel_i,
  input  logic          reg_we_i,
  input  logic [OW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          bus_avail_i,
  input  logic          bus_state_i,
  output logic          halt_o,
  output logic          busy_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_we_o
);
  logic [NREG-1:0][DW-1:0] cfg;
  logic start, grant;

  assign start = reg_we_i && (reg_addr_i == '0);
  assign grant = bus_avail_i && bus_state_i;

  blit_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .regs_nxt_o(cfg)
  );

  blit_seq #(.DW(DW), .AW(AW), .NREG(NREG), .ROW_STRIDE(ROW_STRIDE)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .grant_i    (grant),
    .rev_sel_i,
    .cfg_i      (cfg),
    .mem_rdata_i,
    .halt_o,
    .mem_addr_o,
    .mem_wdata_o,
    .mem_rd_o,
    .mem_we_o
  );

  assign busy_o = halt_o;

  // R2
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(reg_we_i && reg_addr_i == '0));
  // R3
  no_access_first_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !(mem_rd_o || mem_we_o));
  // R3
  access_needs_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_we_o) |-> halt_o);
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb_top;
  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rev_sel = 1'b0, reg_we = 1'b0, bus_avail = 1'b0, bus_state = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic halt, busy, mem_rd, mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_val(mem_addr);

  blit_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rev_sel_i(rev_sel),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .bus_avail_i(bus_avail), .bus_state_i(bus_state),
    .halt_o(halt), .busy_o(busy), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_rd_o(mem_rd), .mem_we_o(mem_we)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected bus cycles; R10 halt release timing
  logic prev_halt = 1'b0, prev_we = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (mem_rd || mem_we) begin
      if (exp_q.size() == 0) begin
        chk("R3/R11 unexpected access", {mem_we, mem_addr, mem_wdata}, 32'h0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk("R6/R7 bus cycle", {mem_we, mem_addr, (mem_we ? mem_wdata : 8'h00)},
            {e.we, e.addr, (e.we ? e.data : 8'h00)});
      end
    end
    if (prev_halt && !halt) chk("R10 release after last write", {prev_we, exp_q.size() == 0}, 2'b11);
    prev_halt = halt;
    prev_we   = mem_we;
  end

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(logic [7:0] fill, logic [15:0] src, logic [15:0] dst,
                       logic [7:0] w, logic [7:0] h);
    wr_reg(3'd1, fill);
    wr_reg(3'd2, src[15:8]); wr_reg(3'd3, src[7:0]);
    wr_reg(3'd4, dst[15:8]); wr_reg(3'd5, dst[7:0]);
    wr_reg(3'd6, w);         wr_reg(3'd7, h);
  endtask

  // expected items from R6..R9
  task automatic push_job(bit fill_m, logic [7:0] fill, logic [15:0] src, logic [15:0] dst,
                          logic [7:0] w, logic [7:0] h, bit rev);
    int we_n = rev ? int'(w ^ 8'h04) : int'(w);
    int he_n = rev ? int'(h ^ 8'h04) : int'(h);
    if (we_n == 0) we_n = 1;
    if (he_n == 0) he_n = 1;
    for (int r = 0; r < he_n; r++)
      for (int c = 0; c < we_n; c++) begin
        logic [15:0] sa = src + 16'(r * 256 + c);
        logic [15:0] da = dst + 16'(r * 256 + c);
        if (fill_m) exp_q.push_back('{1'b1, da, fill});
        else begin
          exp_q.push_back('{1'b0, sa, 8'h00});
          exp_q.push_back('{1'b1, da, mem_val(sa)});
        end
      end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (halt && n < 5000) begin @(negedge clk); n++; end
    chk("R10 idle reached", {31'd0, halt}, 32'd0);
    chk("R6 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset outputs", {halt, busy, mem_rd, mem_we}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {halt, busy, mem_rd, mem_we}, 4'b0000);

    // R2 R3 R4 R5 R6: copy, late width write while waiting
    setup(8'h00, 16'h1234, 16'h4010, 8'd3, 8'd2);
    chk("R2 other offsets no start", {31'd0, halt}, 32'd0);
    wr_reg(3'd0, 8'h00);
    chk("R2 halt/busy after start", {halt, busy}, 2'b11);
    repeat (4) begin
      @(negedge clk);
      chk("R3 no access without ack", {mem_rd, mem_we}, 2'b00);
    end
    bus_avail = 1'b1;
    wr_reg(3'd6, 8'd4); // R4 late width change
    repeat (2) begin
      @(negedge clk);
      chk("R3 bus_avail alone not grant", {mem_rd, mem_we}, 2'b00);
    end
    bus_avail = 1'b0; bus_state = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R3 bus_state alone not grant", {mem_rd, mem_we}, 2'b00);
    end
    push_job(1'b0, 8'h00, 16'h1234, 16'h4010, 8'd4, 8'd2, 1'b0);
    bus_avail = 1'b1;
    wait_idle();
    bus_avail = 1'b0; bus_state = 1'b0;

    // R11: restart attempt while busy
    setup(8'h00, 16'h2000, 16'h3000, 8'd2, 8'd2);
    push_job(1'b0, 8'h00, 16'h2000, 16'h3000, 8'd2, 8'd2, 1'b0);
    bus_avail = 1'b1; bus_state = 1'b1;
    wr_reg(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    wr_reg(3'd0, 8'h00);
    wait_idle();
    repeat (5) begin
      @(negedge clk);
      chk("R11 no second transfer", {halt, mem_rd, mem_we}, 3'b000);
    end

    // R7 fill with address wrap
    setup(8'hA5, 16'h0000, 16'hFFFE, 8'd5, 8'd3);
    push_job(1'b1, 8'hA5, 16'h0000, 16'hFFFE, 8'd5, 8'd3, 1'b0);
    wr_reg(3'd0, 8'h01);
    wait_idle();

    // R8 zero sizes
    setup(8'h00, 16'h0500, 16'h0600, 8'd0, 8'd0);
    push_job(1'b0, 8'h00, 16'h0500, 16'h0600, 8'd0, 8'd0, 1'b0);
    wr_reg(3'd0, 8'h00);
    wait_idle();

    // R9 revision XOR
    rev_sel = 1'b1;
    setup(8'h00, 16'h0A00, 16'h0B00, 8'd6, 8'd5);
    push_job(1'b0, 8'h00, 16'h0A00, 16'h0B00, 8'd6, 8'd5, 1'b1);
    wr_reg(3'd0, 8'h00);
    wait_idle();
    setup(8'h77, 16'h0000, 16'h0C00, 8'd0, 8'd0);
    push_job(1'b1, 8'h77, 16'h0000, 16'h0C00, 8'd0, 8'd0, 1'b1);
    wr_reg(3'd0, 8'h01);
    wait_idle();
    rev_sel = 1'b0;

    // R4 R5: 16-bit store, offset 1 lands in grant cycle
    setup(8'h11, 16'h0000, 16'h0D40, 8'd3, 8'd1);
    push_job(1'b1, 8'h3C, 16'h0000, 16'h0D40, 8'd3, 8'd1, 1'b0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01;
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'h3C;
    @(negedge clk);
    reg_we = 1'b0;
    wait_idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule